// File: doc/BRIEF.md
# Alternating-Batch Issue Scheduler for a Narrow SIMD Shader Core

This block decides, once per scheduler cycle, which element batch issues its next scalar instruction, and to which of two execution resources it goes: a multiply-add lane array, or a shared slot that serves both the attribute interpolator and the special-function unit. Each batch presents the head of its instruction stream as a word on an input. When that head issues, the scheduler pulses the batch's take bit, and the batch then advances to its next instruction. A register scoreboard with one pending bit per batch and register gates issue. Pending bits are set at issue and cleared when the fixed-latency writeback of the resource used has completed.

The scheduler issues at most one instruction per cycle. In pixel mode a two-state turn machine alternates the cycles. On a MAD turn only multiply-add instructions may issue. On a SHARED turn only interpolation or special-function instructions may issue. Because the round-robin pointer moves past the batch that issued last, two batches end up feeding the two resources on alternate cycles. The turn machine has two states, TURN_MAD and TURN_SHARED. Reset enters TURN_MAD. While pixel mode is on, TURN_MAD goes to TURN_SHARED, and TURN_SHARED always returns to TURN_MAD. When pixel mode is off, the machine goes to TURN_MAD from either state. In vertex mode any class may issue on any cycle, so a special-function instruction takes the cycle and the MAD array idles. An end-of-program head retires its batch.

Top module: `simd_issue_sched`

## Requirements
- R1: While rst_n is low, no take bit and no dispatch valid is raised. Reset leaves the turn at TURN_MAD, the round-robin pointer at batch 0, and every pending bit and writeback stage empty.
- R2: At most one instruction is taken per cycle. Each dispatch valid comes with exactly one take bit, which is the bit of the dispatched batch. The MAD and shared dispatch valids are never high together.
- R3: In pixel mode, a MAD head issues only on a TURN_MAD cycle, and an INTERP or SFU head issues only on a TURN_SHARED cycle. The turn toggles on every pixel-mode cycle, whether or not anything issues. After any vertex-mode cycle, the turn is TURN_MAD.
- R4: In vertex mode a head of any class may issue on any cycle. An SFU issued on a cycle leaves the MAD dispatch idle on that cycle.
- R5: A head is blocked while its source A, its source B or its destination is pending in its own batch. An instruction issued in cycle t marks its destination pending. The mark lasts MAD_LAT cycles (default 3) for a MAD, so a dependent may issue at t+4 at the earliest. It lasts SHR_LAT cycles (default 4) for an INTERP or SFU, so a dependent may issue at t+5 at the earliest.
- R6: A register number that is pending in one batch does not block any other batch.
- R7: An INTERP holds the shared slot for INT_OCC cycles (default 1), so another shared-slot instruction may issue on the next cycle. An SFU holds the slot for 4*INT_OCC cycles, so a shared-slot instruction issued in cycle t is followed by the next one no earlier than t+4.
- R8: Batches are searched starting at the one after the last batch that issued, wrapping around. A blocked or invalid batch is skipped. If no batch is eligible, nothing issues.
- R9: An END head is taken in any turn and regardless of the scoreboard. It produces no dispatch and clears all pending bits of its batch.
- R10: The head word is {class[IW-1:IW-2], dst, srcA, srcB}, with each register field RW bits wide. The class codes are MAD=0, INTERP=1, SFU=2, END=3. mad_cls is 0 when mad_vld is high. Every dispatch field is zero while its valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_mode | input | 1 | 1: pixel interleave, 0: vertex/geometry issue |
| head_vld | input | NB | Per batch: head word is present |
| head_word | input | NB*IW | Per-batch head instruction, batch i at bits [i*IW +: IW] |
| head_take | output | NB | One-hot pulse: that batch's head is consumed this cycle |
| mad_vld | output | 1 | MAD array dispatch valid |
| mad_bid | output | BW | Batch id of the MAD dispatch |
| mad_cls | output | 2 | Class of the MAD dispatch (always MAD) |
| mad_dst | output | RW | Destination register of the MAD dispatch |
| shr_vld | output | 1 | Shared-slot dispatch valid |
| shr_bid | output | BW | Batch id of the shared dispatch |
| shr_cls | output | 2 | INTERP or SFU |
| shr_dst | output | RW | Destination register of the shared dispatch |

## Verification
The bench goes after the cycle on which a pending register frees up. A scoreboard cleared one cycle early would let a dependent MAD issue while its producer is still in flight. One cleared late would leave the slot empty where the vector expects an issue. The SFU occupancy window is probed on its last blocked cycle and on its first free cycle, and a short counter would issue an interpolation into an occupied unit. The turn is checked after a two-cycle vertex stretch that starts from TURN_SHARED. A machine that kept toggling in vertex mode would then hand the MAD turn to the waiting interpolation. The bench also covers a retire that clears a pending source, a round-robin skip past a blocked preferred batch, and a reused register number in another batch. If any of these were wrong, the design would stall where it should issue, or issue where it should wait.

// File: rtl/sched_pkg.sv
package sched_pkg;

    // Class code carried in the top two bits of a head word.
    typedef enum logic [1:0] {
        OP_MAD    = 2'd0,
        OP_INTERP = 2'd1,
        OP_SFU    = 2'd2,
        OP_END    = 2'd3
    } op_cls_e;

    // Pixel-mode turn of the single issue port.
    typedef enum logic {
        TURN_MAD    = 1'b0,
        TURN_SHARED = 1'b1
    } turn_e;

endpackage

// File: rtl/sched_wb_pipe.sv
module sched_wb_pipe #(
    parameter int DEPTH = 3,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);

    logic [DEPTH-1:0] stg_v;
    logic [W-1:0]     stg_d [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_v[0] <= 1'b0;
                    stg_d[0] <= '0;
                end else begin
                    stg_v[0] <= in_v;
                    stg_d[0] <= in_d;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_v[s] <= 1'b0;
                    stg_d[s] <= '0;
                end else begin
                    stg_v[s] <= stg_v[s-1];
                    stg_d[s] <= stg_d[s-1];
                end
            end
        end
    end

    assign out_v = stg_v[DEPTH-1];
    assign out_d = stg_d[DEPTH-1];

endmodule

// File: rtl/sched_scoreboard.sv
module sched_scoreboard #(
    parameter int NB      = 4,
    parameter int NREG    = 8,
    parameter int MAD_LAT = 3,
    parameter int SHR_LAT = 4,
    parameter int BW      = 2,
    parameter int RW      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_vld,
    input  logic               set_shared,
    input  logic [BW-1:0]      set_bid,
    input  logic [RW-1:0]      set_dst,
    input  logic               ret_vld,
    input  logic [BW-1:0]      ret_bid,
    output logic [NB*NREG-1:0] pend
);

    localparam int TW = BW + RW;

    logic [NB*NREG-1:0] pend_q, pend_d;
    logic               mad_wb_v, shr_wb_v;
    logic [TW-1:0]      mad_wb_t, shr_wb_t;

    sched_wb_pipe #(.DEPTH(MAD_LAT), .W(TW)) i_mad_wb (
        .clk(clk), .rst_n(rst_n),
        .in_v(set_vld && !set_shared), .in_d({set_bid, set_dst}),
        .out_v(mad_wb_v), .out_d(mad_wb_t)
    );

    sched_wb_pipe #(.DEPTH(SHR_LAT), .W(TW)) i_shr_wb (
        .clk(clk), .rst_n(rst_n),
        .in_v(set_vld && set_shared), .in_d({set_bid, set_dst}),
        .out_v(shr_wb_v), .out_d(shr_wb_t)
    );

    always_comb begin
        pend_d = pend_q;
        if (mad_wb_v)
            pend_d[int'(mad_wb_t[TW-1 -: BW])*NREG + int'(mad_wb_t[RW-1:0])] = 1'b0;
        if (shr_wb_v)
            pend_d[int'(shr_wb_t[TW-1 -: BW])*NREG + int'(shr_wb_t[RW-1:0])] = 1'b0;
        if (set_vld)
            pend_d[int'(set_bid)*NREG + int'(set_dst)] = 1'b1;
        if (ret_vld)
            pend_d[int'(ret_bid)*NREG +: NREG] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    // R5: a destination is never marked twice while still in flight
    p_no_double_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |-> !pend_q[int'(set_bid)*NREG + int'(set_dst)]);

    // R9: a retired batch has no pending register on the following cycle
    p_retire_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld |=> (pend_q[int'($past(ret_bid))*NREG +: NREG] == '0));

endmodule

// File: rtl/sched_pick.sv
module sched_pick
    import sched_pkg::*;
#(
    parameter int NB   = 4,
    parameter int NREG = 8,
    parameter int RW   = 3,
    parameter int IW   = 11,
    parameter int BW   = 2
) (
    input  logic [BW-1:0]      rr,
    input  logic [NB-1:0]      head_vld,
    input  logic [NB*IW-1:0]   head_word,
    input  logic [NB*NREG-1:0] pend,
    input  logic               allow_mad,
    input  logic               allow_shr,
    input  logic               shr_free,
    output logic               found,
    output logic [BW-1:0]      sel
);

    logic [NB-1:0] elig;

    for (genvar i = 0; i < NB; i++) begin : g_batch
        logic [IW-1:0]   w;
        logic [NREG-1:0] row;
        op_cls_e         cls;
        logic            hazard;

        assign w      = head_word[i*IW +: IW];
        assign row    = pend[i*NREG +: NREG];
        assign cls    = op_cls_e'(w[IW-1 -: 2]);
        assign hazard = row[w[3*RW-1 -: RW]] | row[w[2*RW-1 -: RW]] | row[w[RW-1:0]];

        always_comb begin
            elig[i] = 1'b0;
            if (head_vld[i]) begin
                unique case (cls)
                    OP_END:           elig[i] = 1'b1;
                    OP_MAD:           elig[i] = allow_mad && !hazard;
                    OP_INTERP,
                    OP_SFU:           elig[i] = allow_shr && shr_free && !hazard;
                    default:          elig[i] = 1'b0;
                endcase
            end
        end
    end

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < NB; k++) begin
            if (!found && elig[(int'(rr) + k) % NB]) begin
                found = 1'b1;
                sel   = BW'((int'(rr) + k) % NB);
            end
        end
    end

endmodule

// File: rtl/simd_issue_sched.sv
module simd_issue_sched
    import sched_pkg::*;
#(
    parameter int NB      = 4,
    parameter int NREG    = 8,
    parameter int MAD_LAT = 3,
    parameter int SHR_LAT = 4,
    parameter int INT_OCC = 1,
    localparam int BW     = (NB > 1) ? $clog2(NB) : 1,
    localparam int RW     = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int IW     = 2 + 3*RW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_mode,
    input  logic [NB-1:0]    head_vld,
    input  logic [NB*IW-1:0] head_word,
    output logic [NB-1:0]    head_take,
    output logic             mad_vld,
    output logic [BW-1:0]    mad_bid,
    output logic [1:0]       mad_cls,
    output logic [RW-1:0]    mad_dst,
    output logic             shr_vld,
    output logic [BW-1:0]    shr_bid,
    output logic [1:0]       shr_cls,
    output logic [RW-1:0]    shr_dst
);

    localparam int SFU_OCC = 4 * INT_OCC;
    localparam int CW      = $clog2(SFU_OCC + 1);

    turn_e              turn_q, turn_d;
    logic [BW-1:0]      rr_q, sel;
    logic [CW-1:0]      busy_q;
    logic [NB*NREG-1:0] pend;
    logic               found, go, ret_go;
    logic [IW-1:0]      sel_word;
    op_cls_e            sel_cls;
    logic [RW-1:0]      sel_dst;

    // ---- turn state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) turn_q <= TURN_MAD;
        else        turn_q <= turn_d;
    end

    always_comb begin
        turn_d = TURN_MAD;
        unique case (turn_q)
            TURN_MAD:    turn_d = pix_mode ? TURN_SHARED : TURN_MAD;
            TURN_SHARED: turn_d = TURN_MAD;
            default:     turn_d = TURN_MAD;
        endcase
    end

    sched_pick #(.NB(NB), .NREG(NREG), .RW(RW), .IW(IW), .BW(BW)) i_pick (
        .rr(rr_q), .head_vld(head_vld), .head_word(head_word), .pend(pend),
        .allow_mad(!pix_mode || turn_q == TURN_MAD),
        .allow_shr(!pix_mode || turn_q == TURN_SHARED),
        .shr_free(busy_q == '0),
        .found(found), .sel(sel)
    );

    assign go       = rst_n && found;
    assign sel_word = head_word[int'(sel)*IW +: IW];
    assign sel_cls  = op_cls_e'(sel_word[IW-1 -: 2]);
    assign sel_dst  = sel_word[3*RW-1 -: RW];
    assign ret_go   = go && sel_cls == OP_END;

    // ---- dispatch outputs ----
    always_comb begin
        head_take = '0;
        mad_vld = 1'b0; mad_bid = '0; mad_cls = 2'd0; mad_dst = '0;
        shr_vld = 1'b0; shr_bid = '0; shr_cls = 2'd0; shr_dst = '0;
        if (go) begin
            head_take[sel] = 1'b1;
            unique case (sel_cls)
                OP_MAD: begin
                    mad_vld = 1'b1; mad_bid = sel; mad_cls = OP_MAD; mad_dst = sel_dst;
                end
                OP_INTERP, OP_SFU: begin
                    shr_vld = 1'b1; shr_bid = sel; shr_cls = sel_cls; shr_dst = sel_dst;
                end
                default: ;
            endcase
        end
    end

    // ---- round-robin pointer and shared-slot occupancy ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q   <= '0;
            busy_q <= '0;
        end else begin
            if (go)
                rr_q <= (int'(sel) == NB-1) ? '0 : sel + 1'b1;
            if (shr_vld)
                busy_q <= (sel_cls == OP_SFU) ? CW'(SFU_OCC - 1) : CW'(INT_OCC - 1);
            else if (busy_q != '0)
                busy_q <= busy_q - 1'b1;
        end
    end

    sched_scoreboard #(.NB(NB), .NREG(NREG), .MAD_LAT(MAD_LAT), .SHR_LAT(SHR_LAT),
                       .BW(BW), .RW(RW)) i_sb (
        .clk(clk), .rst_n(rst_n),
        .set_vld(go && !ret_go), .set_shared(sel_cls != OP_MAD),
        .set_bid(sel), .set_dst(sel_dst),
        .ret_vld(ret_go), .ret_bid(sel),
        .pend(pend)
    );

    // R2: single issue per cycle
    p_one_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(head_take));
    p_disp_needs_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mad_vld || shr_vld) |-> ($countones(head_take) == 1 && !(mad_vld && shr_vld)));
    // R3: in pixel mode a MAD issue is never followed by another MAD issue
    p_pix_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_mode && mad_vld) |=> (!pix_mode || !mad_vld));
    // R7: an SFU keeps the shared slot occupied on the following cycle
    p_sfu_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shr_vld && shr_cls == OP_SFU) |=> !shr_vld);

endmodule

// File: tb/test_simd_issue_sched.sv
`timescale 1ns/1ps
module test_simd_issue_sched;

    localparam int CM = 0, CI = 1, CS = 2, CE = 3;

    typedef struct packed {
        logic        pix;
        logic [3:0]  hv;
        logic [10:0] w3, w2, w1, w0;
        logic [3:0]  take;
        logic        mv;
        logic [1:0]  mb;
        logic [2:0]  md;
        logic        sv;
        logic [1:0]  sb;
        logic [1:0]  sc;
        logic [2:0]  sd;
        logic [3:0]  req;
    } vec_t;

    // head word per R10: {class, dst, srcA, srcB}
    function automatic logic [10:0] iw(int c, int d, int a, int b);
        return {2'(c), 3'(d), 3'(a), 3'(b)};
    endfunction

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        // c0..c7 vertex mode: R4 R8 R10 R6 R5 R7
        '{1'b0, 4'b0011, 11'd0, 11'd0, iw(CM,2,0,0), iw(CM,1,0,0), 4'b0001, 1'b1, 2'd0, 3'd1, 1'b0, 2'd0, 2'd0, 3'd0, 4'd4},
        '{1'b0, 4'b0011, 11'd0, 11'd0, iw(CM,2,0,0), iw(CM,3,1,1), 4'b0010, 1'b1, 2'd1, 3'd2, 1'b0, 2'd0, 2'd0, 3'd0, 4'd8},
        '{1'b0, 4'b0011, 11'd0, 11'd0, iw(CS,4,5,6), iw(CM,3,1,1), 4'b0010, 1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 2'd2, 3'd4, 4'd10},
        '{1'b0, 4'b0111, 11'd0, iw(CM,1,0,0), iw(CI,5,0,0), iw(CM,3,1,1), 4'b0100, 1'b1, 2'd2, 3'd1, 1'b0, 2'd0, 2'd0, 3'd0, 4'd6},
        '{1'b0, 4'b0011, 11'd0, 11'd0, iw(CI,5,0,0), iw(CM,3,1,1), 4'b0001, 1'b1, 2'd0, 3'd3, 1'b0, 2'd0, 2'd0, 3'd0, 4'd5},
        '{1'b0, 4'b0010, 11'd0, 11'd0, iw(CI,5,0,0), 11'd0,        4'b0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd7},
        '{1'b0, 4'b0010, 11'd0, 11'd0, iw(CI,5,0,0), 11'd0,        4'b0010, 1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 2'd1, 3'd5, 4'd7},
        '{1'b0, 4'b0011, 11'd0, 11'd0, iw(CI,6,0,0), iw(CM,7,3,3), 4'b0010, 1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 2'd1, 3'd6, 4'd7},
        // c8..c16 pixel mode alternation: R3 R7
        '{1'b1, 4'b0011, 11'd0, 11'd0, iw(CI,7,0,0), iw(CM,7,3,3), 4'b0001, 1'b1, 2'd0, 3'd7, 1'b0, 2'd0, 2'd0, 3'd0, 4'd3},
        '{1'b1, 4'b0011, 11'd0, 11'd0, iw(CI,7,0,0), iw(CM,0,1,1), 4'b0010, 1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 2'd1, 3'd7, 4'd3},
        '{1'b1, 4'b0011, 11'd0, 11'd0, iw(CS,1,2,3), iw(CM,0,1,1), 4'b0001, 1'b1, 2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd3},
        '{1'b1, 4'b0011, 11'd0, 11'd0, iw(CS,1,2,3), iw(CM,2,1,1), 4'b0010, 1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 2'd2, 3'd1, 4'd3},
        '{1'b1, 4'b0011, 11'd0, 11'd0, iw(CI,2,0,0), iw(CM,2,1,1), 4'b0001, 1'b1, 2'd0, 3'd2, 1'b0, 2'd0, 2'd0, 3'd0, 4'd3},
        '{1'b1, 4'b0011, 11'd0, 11'd0, iw(CI,2,0,0), iw(CM,4,1,1), 4'b0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd3},
        '{1'b1, 4'b0011, 11'd0, 11'd0, iw(CI,2,0,0), iw(CM,4,1,1), 4'b0001, 1'b1, 2'd0, 3'd4, 1'b0, 2'd0, 2'd0, 3'd0, 4'd3},
        '{1'b1, 4'b0010, 11'd0, 11'd0, iw(CI,2,0,0), 11'd0,        4'b0010, 1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 2'd1, 3'd2, 4'd7},
        '{1'b1, 4'b0010, 11'd0, 11'd0, iw(CI,3,0,0), 11'd0,        4'b0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd3},
        // c17..c19 vertex stretch from TURN_SHARED, then pixel: R4 R3
        '{1'b0, 4'b0011, 11'd0, 11'd0, iw(CI,3,0,0), iw(CM,5,1,1), 4'b0001, 1'b1, 2'd0, 3'd5, 1'b0, 2'd0, 2'd0, 3'd0, 4'd4},
        '{1'b0, 4'b0010, 11'd0, 11'd0, iw(CI,3,0,0), 11'd0,        4'b0010, 1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 2'd1, 3'd3, 4'd4},
        '{1'b1, 4'b0011, 11'd0, 11'd0, iw(CI,4,0,0), iw(CM,6,1,1), 4'b0001, 1'b1, 2'd0, 3'd6, 1'b0, 2'd0, 2'd0, 3'd0, 4'd3},
        // c20..c23 shared-latency dependency: R5
        '{1'b0, 4'b0010, 11'd0, 11'd0, iw(CM,0,3,3), 11'd0,        4'b0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd5},
        '{1'b0, 4'b0010, 11'd0, 11'd0, iw(CM,0,3,3), 11'd0,        4'b0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd5},
        '{1'b0, 4'b0010, 11'd0, 11'd0, iw(CM,0,3,3), 11'd0,        4'b0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd5},
        '{1'b0, 4'b0010, 11'd0, 11'd0, iw(CM,0,3,3), 11'd0,        4'b0010, 1'b1, 2'd1, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd5},
        // c24..c25 retire clears the batch: R9
        '{1'b0, 4'b0010, 11'd0, 11'd0, iw(CE,0,0,0), 11'd0,        4'b0010, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd9},
        '{1'b0, 4'b0010, 11'd0, 11'd0, iw(CM,4,0,0), 11'd0,        4'b0010, 1'b1, 2'd1, 3'd4, 1'b0, 2'd0, 2'd0, 3'd0, 4'd9},
        // c26..c29 round-robin with skip: R8 R5
        '{1'b0, 4'b1101, iw(CM,1,0,0), iw(CM,2,0,0), 11'd0, iw(CM,5,1,1), 4'b0100, 1'b1, 2'd2, 3'd2, 1'b0, 2'd0, 2'd0, 3'd0, 4'd8},
        '{1'b0, 4'b1101, iw(CM,1,0,0), iw(CM,3,0,0), 11'd0, iw(CM,5,1,1), 4'b1000, 1'b1, 2'd3, 3'd1, 1'b0, 2'd0, 2'd0, 3'd0, 4'd8},
        '{1'b0, 4'b0110, 11'd0, iw(CM,3,0,0), iw(CM,5,4,4), 11'd0, 4'b0100, 1'b1, 2'd2, 3'd3, 1'b0, 2'd0, 2'd0, 3'd0, 4'd8},
        '{1'b0, 4'b0010, 11'd0, 11'd0, iw(CM,5,4,4), 11'd0,        4'b0010, 1'b1, 2'd1, 3'd5, 1'b0, 2'd0, 2'd0, 3'd0, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_mode = 1'b0;
    logic [3:0]  head_vld = '0;
    logic [43:0] head_word = '0;
    logic [3:0]  head_take;
    logic        mad_vld, shr_vld;
    logic [1:0]  mad_bid, shr_bid, mad_cls, shr_cls;
    logic [2:0]  mad_dst, shr_dst;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    simd_issue_sched i_simd_issue_sched (
        .clk(clk), .rst_n(rst_n), .pix_mode(pix_mode),
        .head_vld(head_vld), .head_word(head_word), .head_take(head_take),
        .mad_vld(mad_vld), .mad_bid(mad_bid), .mad_cls(mad_cls), .mad_dst(mad_dst),
        .shr_vld(shr_vld), .shr_bid(shr_bid), .shr_cls(shr_cls), .shr_dst(shr_dst)
    );

    task automatic drive(input vec_t v);
        pix_mode  = v.pix;
        head_vld  = v.hv;
        head_word = {v.w3, v.w2, v.w1, v.w0};
    endtask

    task automatic check(input vec_t v, input int idx);
        logic [20:0] got, exp;
        got = {head_take, mad_vld, mad_bid, mad_dst, mad_cls, shr_vld, shr_bid, shr_cls, shr_dst};
        exp = {v.take, v.mv, v.mb, v.md, 2'b00, v.sv, v.sb, v.sc, v.sd};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d step %0d: got %h expected %h", v.req, idx, got, exp);
        end
    endtask

    initial begin
        vec_t v;
        // R1: outputs stay quiet while reset is held, even with a ready head
        v = '{1'b0, 4'b0001, 11'd0, 11'd0, 11'd0, iw(CM,1,0,0), 4'b0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd1};
        @(negedge clk); drive(v); #2 check(v, -1);
        @(negedge clk); #2 check(v, -2);

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rst_n = 1'b1;
            drive(TBL[i]);
            #2 check(TBL[i], i);
        end

        // R1: reset in the middle of a run, b1 r5 still in flight
        v = '{1'b0, 4'b0010, 11'd0, 11'd0, iw(CM,7,5,5), 11'd0, 4'b0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd1};
        @(negedge clk); rst_n = 1'b0; drive(v); #2 check(v, 100);
        // R1: after release the pending bit is gone, so b1 issues at once
        v.take = 4'b0010; v.mv = 1'b1; v.mb = 2'd1; v.md = 3'd7;
        @(negedge clk); rst_n = 1'b1; drive(v); #2 check(v, 101);
        // R1 R3: pixel mode after reset opens with the MAD turn, INTERP waits
        v = '{1'b1, 4'b0010, 11'd0, 11'd0, iw(CI,6,0,0), 11'd0, 4'b0000, 1'b0, 2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 3'd0, 4'd3};
        @(negedge clk); drive(v); #2 check(v, 102);
        // R3: the next cycle is the shared turn
        v.take = 4'b0010; v.sv = 1'b1; v.sb = 2'd1; v.sc = 2'd1; v.sd = 3'd6;
        @(negedge clk); drive(v); #2 check(v, 103);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule